// File: doc/BRIEF.md
# Oversampling UART Receiver with Break Detection

This block turns an asynchronous serial line into characters. The line is first brought into the clock domain through a two-stage synchronizer. A free-running divider then produces an oversampling tick every N clocks. The receiver runs at either 16 or 13 ticks per bit. A falling line seen on a tick is taken as a possible start bit. The start bit is confirmed only if the line is still low half a bit later. After that, each data bit, the optional parity bit and the first stop bit are sampled at their centre ticks.

The character format is set by the same fields the matching transmitter uses: 5 to 8 data bits, parity that is none, even or odd, and a stop length of 1, 1.5 or 2 bits. Each character is reported with a one-clock valid strobe. The strobe carries the right-aligned data and three flags: parity error, framing error and break. A break means that the whole frame, including the stop bit, was sampled low. After a break the receiver ignores the line until it has gone high again. The configuration inputs must be held stable while a frame is being received.

Top module: `uart_rx_core`

## Requirements
- R1: While rst_n is low, and in the first clock after it is released, out_valid, out_data, out_perr, out_ferr and out_brk are all zero.
- R2: An oversampling tick occurs once every baud_div_m1+1 clocks, counted by a divider that starts at zero after reset. A bit lasts 16 ticks when os13 is 0 and 13 ticks when os13 is 1.
- R3: When idle, a low synchronized line on a tick starts a frame. The line is sampled again 8 ticks later (os13=0) or 6 ticks later (os13=1). If it is high then, the frame is dropped and no character is reported.
- R4: data_bits codes the character length: 0 means 5 bits, 1 means 6, 2 means 7 and 3 means 8. Data bits are sampled one bit period apart, starting one bit period after the start-bit check, and are received LSB first. They are placed in out_data right-aligned, and the unused upper bits are zero.
- R5: With parity_en=1, one parity bit follows the data. out_perr is set when the XOR of the data bits, the parity bit and parity_odd is 1. With parity_en=0 there is no parity bit and out_perr stays 0.
- R6: Only the first stop bit is sampled. If it is low, out_ferr is set.
- R7: If the start bit, all data bits, the parity bit (when enabled) and the stop bit are all sampled low, the strobe reports out_brk=1 and out_ferr=1, with out_perr=0 and out_data=0. No new start is then accepted until the line has been seen high on a tick.
- R8: stop_sel codes the stop length: 0 means 1 bit, 1 means 1.5 bits and 2 means 2 bits. After the stop-bit sample, the receiver ignores the line for 0 ticks, half a bit (8 or 6 ticks) or a whole bit (16 or 13 ticks) respectively, and then resumes start detection.
- R9: out_valid is a one-clock pulse in the clock after the tick on which the stop bit is sampled. Whenever out_valid is 0, the data and flag outputs are 0.
- R10: rxd reaches the sampling logic through two flip-flops, so a sample taken at a clock edge sees the value rxd had two edges earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os13 | input | 1 | 1 selects 13 ticks per bit, 0 selects 16 |
| baud_div_m1 | input | 14 | Divisor N minus one (N from 1 to 16384) |
| data_bits | input | 2 | Character length code (5 to 8 bits) |
| parity_en | input | 1 | Parity bit present |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_sel | input | 2 | Stop length code (1, 1.5 or 2 bits) |
| rxd | input | 1 | Asynchronous serial input, idle high |
| out_valid | output | 1 | One-clock character strobe |
| out_data | output | 8 | Received character, right-aligned |
| out_perr | output | 1 | Parity error for this character |
| out_ferr | output | 1 | Framing error for this character |
| out_brk | output | 1 | Break detected |

## Verification
Break detection and the framing-error flag fire on the same stop-bit sample. The bench provokes this by holding the line low across a whole frame with parity enabled, and also by a zero character whose stop bit alone is high. It expects both flags together in the first case and neither in the second. The framing flag alone is provoked by a non-zero character with a low stop bit. A behavioural tick-position model predicts every output on every clock, so a strobe that arrives one clock early or late, or a flag that is missing, shows up as a miscompare.

// File: rtl/uart_rx_pkg.sv
// Shared types for the UART receiver.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_GUARD,
        RX_BRKWAIT
    } rx_state_e;

endpackage

// File: rtl/uart_rx_sync.sv
// Multi-stage synchronizer for the asynchronous serial line.
// Assumes: the line idles high, so every stage resets to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_baud.sv
// Free-running divider that produces the oversampling tick.
// Assumes: the divisor is held stable; the tick is high in the last clock of each period.
module uart_rx_baud #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt == div_m1);

    // Count clocks and wrap at the programmed divisor.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_rx_fsm.sv
// Frame sequencer: start validation, centre sampling, parity, stop and break.
// Assumes: the format inputs are stable for the whole frame; rx_s is already synchronized.
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_s,
    input  logic              os13,
    input  logic [1:0]        data_bits,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [1:0]        stop_sel,
    output logic              emit,
    output logic [DATA_W-1:0] e_data,
    output logic              e_perr,
    output logic              e_ferr,
    output logic              e_brk
);
    localparam int TCNT_W  = $clog2(OS_HI + 1);
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int HALF_HI = OS_HI / 2;
    localparam int HALF_LO = OS_LO / 2;

    rx_state_e         state;
    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W-1:0] per_m1;
    logic [TCNT_W-1:0] half_m1;
    logic [TCNT_W-1:0] guard;
    logic [IDX_W-1:0]  bidx;
    logic [IDX_W-1:0]  last_idx;
    logic [DATA_W-1:0] shreg;
    logic              pbit;
    logic              all_low;
    logic              brk_now;
    logic              par_bad;

    // Derive bit period, centre offset, holdoff and last data index from the format.
    always_comb begin
        per_m1   = os13 ? TCNT_W'(OS_LO - 1)   : TCNT_W'(OS_HI - 1);
        half_m1  = os13 ? TCNT_W'(HALF_LO - 1) : TCNT_W'(HALF_HI - 1);
        last_idx = IDX_W'(data_bits) + IDX_W'(DATA_W - 4);
        case (stop_sel)
            2'd0:    guard = '0;
            2'd1:    guard = half_m1 + 1'b1;
            default: guard = per_m1 + 1'b1;
        endcase
    end

    // Judge the stop-bit sample: break and parity outcome.
    always_comb begin
        brk_now = all_low & ~rx_s;
        par_bad = parity_en & (^shreg ^ pbit ^ parity_odd);
    end

    // Advance the frame on each tick and load the result registers at the stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= RX_IDLE;
            tcnt    <= '0;
            bidx    <= '0;
            shreg   <= '0;
            pbit    <= 1'b0;
            all_low <= 1'b0;
            emit    <= 1'b0;
            e_data  <= '0;
            e_perr  <= 1'b0;
            e_ferr  <= 1'b0;
            e_brk   <= 1'b0;
        end else begin
            emit   <= 1'b0;
            e_data <= '0;
            e_perr <= 1'b0;
            e_ferr <= 1'b0;
            e_brk  <= 1'b0;
            if (tick) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx_s) begin
                            state <= RX_START;
                            tcnt  <= '0;
                        end
                    end
                    RX_START: begin
                        if (tcnt == half_m1) begin
                            tcnt    <= '0;
                            bidx    <= '0;
                            shreg   <= '0;
                            pbit    <= 1'b0;
                            all_low <= 1'b1;
                            state   <= rx_s ? RX_IDLE : RX_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (tcnt == per_m1) begin
                            tcnt        <= '0;
                            shreg[bidx] <= rx_s;
                            all_low     <= all_low & ~rx_s;
                            if (bidx == last_idx) state <= parity_en ? RX_PAR : RX_STOP;
                            else                  bidx  <= bidx + 1'b1;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_PAR: begin
                        if (tcnt == per_m1) begin
                            tcnt    <= '0;
                            pbit    <= rx_s;
                            all_low <= all_low & ~rx_s;
                            state   <= RX_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == per_m1) begin
                            tcnt   <= '0;
                            emit   <= 1'b1;
                            e_brk  <= brk_now;
                            e_ferr <= ~rx_s;
                            e_perr <= brk_now ? 1'b0 : par_bad;
                            e_data <= brk_now ? '0 : shreg;
                            if (brk_now)          state <= RX_BRKWAIT;
                            else if (guard == '0) state <= RX_IDLE;
                            else                  state <= RX_GUARD;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_GUARD: begin
                        if (tcnt == guard - 1'b1) state <= RX_IDLE;
                        else                      tcnt  <= tcnt + 1'b1;
                    end
                    RX_BRKWAIT: begin
                        if (rx_s) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_core.sv
// UART receiver top: synchronizer, oversampling divider and frame sequencer.
// Assumes: configuration inputs change only while the line is idle.
module uart_rx_core #(
    parameter int DIV_W  = 14,
    parameter int DATA_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os13,
    input  logic [DIV_W-1:0]  baud_div_m1,
    input  logic [1:0]        data_bits,
    input  logic              parity_en,
    input  logic              parity_odd,
    input  logic [1:0]        stop_sel,
    input  logic              rxd,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_perr,
    output logic              out_ferr,
    output logic              out_brk
);
    logic rx_s;
    logic tick;

    uart_rx_sync #(.STAGES(SYNC_N)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    uart_rx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk   (clk),
        .rst_n (rst_n),
        .div_m1(baud_div_m1),
        .tick  (tick)
    );

    uart_rx_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_s      (rx_s),
        .os13      (os13),
        .data_bits (data_bits),
        .parity_en (parity_en),
        .parity_odd(parity_odd),
        .stop_sel  (stop_sel),
        .emit      (out_valid),
        .e_data    (out_data),
        .e_perr    (out_perr),
        .e_ferr    (out_ferr),
        .e_brk     (out_brk)
    );
endmodule

// File: rtl/uart_rx_core_chk.sv
// Property checker for the UART receiver, attached to the top by bind.
// Assumes: configuration is stable while a character strobe is out.
module uart_rx_core_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        data_bits,
    input logic              parity_en,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_perr,
    input logic              out_ferr,
    input logic              out_brk
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid); // R9

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_data == '0 && !out_perr && !out_ferr && !out_brk)); // R9

    AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        out_brk |-> (out_ferr && !out_perr && out_data == '0)); // R7

    AST_PERR_NEEDS_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        out_perr |-> parity_en); // R5

    AST_SHORT_CHAR_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && data_bits == 2'd0) |-> ((out_data >> 5) == '0)); // R4
endmodule

bind uart_rx_core uart_rx_core_chk #(.DATA_W(DATA_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_bits(data_bits),
    .parity_en(parity_en),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_perr (out_perr),
    .out_ferr (out_ferr),
    .out_brk  (out_brk)
);

// File: tb/uart_rx_core_tb_top.sv
`timescale 1ns/1ps
// Bench: a behavioural tick-position model predicts every output on every clock.
module uart_rx_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        os13_r = 1'b0;
    logic [13:0] div_r = 14'd1;
    logic [1:0]  db_r = 2'd3;
    logic        pen_r = 1'b0;
    logic        podd_r = 1'b0;
    logic [1:0]  ssel_r = 2'd0;
    logic        rxd = 1'b1;
    logic        out_valid;
    logic [7:0]  out_data;
    logic        out_perr, out_ferr, out_brk;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    seen_edge = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    uart_rx_core dut_i (
        .clk(clk), .rst_n(rst_n), .os13(os13_r), .baud_div_m1(div_r),
        .data_bits(db_r), .parity_en(pen_r), .parity_odd(podd_r),
        .stop_sel(ssel_r), .rxd(rxd), .out_valid(out_valid),
        .out_data(out_data), .out_perr(out_perr), .out_ferr(out_ferr),
        .out_brk(out_brk)
    );

    // Reference model state
    int         m_q1, m_q2, m_mc, m_mode, m_pos, m_g;
    logic [7:0] m_dat;
    int         m_pb, m_low;
    int         e_v, e_pe, e_fe, e_bk;
    logic [7:0] e_d;

    always @(posedge clk) begin : model
        int ls, tk, j, per, half, nb, gd, brk;
        seen_edge = 1'b1;
        e_v = 0; e_d = 8'h00; e_pe = 0; e_fe = 0; e_bk = 0;
        if (!rst_n) begin
            m_q1 = 1; m_q2 = 1; m_mc = 0; m_mode = 0; m_pos = 0; m_g = 0;
        end else begin
            ls = m_q2; m_q2 = m_q1; m_q1 = rxd;         // R10 two-stage delay
            tk = (m_mc == int'(div_r));                 // R2 divider
            m_mc = tk ? 0 : m_mc + 1;
            per  = os13_r ? 13 : 16;
            half = os13_r ? 6 : 8;
            nb   = 5 + int'(db_r);
            gd   = (ssel_r == 2'd0) ? 0 : (ssel_r == 2'd1) ? half : per;
            if (tk) begin
                case (m_mode)
                    0: if (ls == 0) begin m_mode = 1; m_pos = 0; end
                    1: begin
                        m_pos++;
                        if (m_pos == half) begin
                            if (ls != 0) m_mode = 0;
                            else begin m_dat = 8'h00; m_low = 1; m_pb = 0; end
                        end else if (m_pos > half && (m_pos - half) % per == 0) begin
                            j = (m_pos - half) / per;
                            if (j <= nb) begin
                                m_dat[j-1] = ls[0];
                                if (ls != 0) m_low = 0;
                            end else if (pen_r && j == nb + 1) begin
                                m_pb = ls;
                                if (ls != 0) m_low = 0;
                            end else begin
                                brk = (m_low != 0 && ls == 0);
                                e_v = 1;
                                e_fe = (ls == 0);
                                e_bk = brk;
                                e_d  = brk ? 8'h00 : m_dat;
                                e_pe = brk ? 0 : int'(pen_r && ((^m_dat) ^ m_pb[0] ^ podd_r));
                                if (brk) m_mode = 3;
                                else if (gd == 0) m_mode = 0;
                                else begin m_mode = 2; m_g = gd; end
                            end
                        end
                    end
                    2: begin m_g--; if (m_g == 0) m_mode = 0; end
                    3: if (ls != 0) m_mode = 0;
                    default: m_mode = 0;
                endcase
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    // Compare every output on every clock, away from the active edge.
    always @(negedge clk) begin
        if (seen_edge && !done) begin
            chk(cur_req, int'(out_valid), e_v);    // valid timing per scenario
            chk("R4", int'(out_data), int'(e_d));   // data bits
            chk("R5", int'(out_perr), e_pe);        // parity
            chk("R6", int'(out_ferr), e_fe);        // framing
            chk("R7", int'(out_brk), e_bk);         // break
        end
    end

    function automatic int bclk();
        return (os13_r ? 13 : 16) * (int'(div_r) + 1);
    endfunction

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    // Send one frame; stop_halves = stop length in half bits.
    task automatic send(input logic [7:0] d, input bit flip_par,
                        input bit stop_low, input int stop_halves);
        int  nb = 5 + int'(db_r);
        logic p = 1'b0;
        hold(1'b0, bclk());
        for (int i = 0; i < nb; i++) begin
            p ^= d[i];
            hold(d[i], bclk());
        end
        if (pen_r) hold(p ^ podd_r ^ flip_par, bclk());
        hold(!stop_low, stop_halves * bclk() / 2);
        rxd = 1'b1;
    endtask

    task automatic gap(input int bits);
        hold(1'b1, bits * bclk());
    endtask

    initial begin : stim
        @(negedge clk);
        cur_req = "R1";                                // R1 reset state
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        cur_req = "R2";                                // R2 16x, N=2, 8N1
        send(8'hA5, 0, 0, 2); gap(2);
        send(8'h3C, 0, 0, 2); gap(2);

        cur_req = "R4";                                // R4 7E1 at 13x, N=3
        os13_r = 1; div_r = 14'd2; db_r = 2'd2; pen_r = 1; podd_r = 0; gap(1);
        send(8'h55, 0, 0, 2); gap(2);
        cur_req = "R5";                                // R5 bad even parity
        send(8'h2B, 1, 0, 2); gap(2);

        cur_req = "R5";                                // R5 5 bits odd, 2 stop
        os13_r = 0; div_r = 14'd1; db_r = 2'd0; podd_r = 1; ssel_r = 2'd2; gap(1);
        send(8'h13, 0, 0, 4); gap(2);
        send(8'h0E, 1, 0, 4); gap(2);

        cur_req = "R6";                                // R6 6N1 low stop bit
        db_r = 2'd1; pen_r = 0; ssel_r = 2'd0; gap(1);
        send(8'h2D, 0, 1, 2); gap(2);

        cur_req = "R7";                                // R7 break with 8E1
        db_r = 2'd3; pen_r = 1; podd_r = 0; gap(1);
        hold(1'b0, 14 * bclk()); gap(3);
        send(8'h00, 0, 0, 2); gap(2);                  // R7 zero char, not a break
        cur_req = "R7";                                // R7 break at 13x, no parity
        os13_r = 1; pen_r = 0; gap(1);
        hold(1'b0, 12 * bclk()); gap(3);

        cur_req = "R3";                                // R3 short glitches rejected
        os13_r = 0; div_r = 14'd1; gap(1);
        hold(1'b0, 6); gap(2);
        hold(1'b0, 12); gap(2);
        os13_r = 1; gap(1);
        hold(1'b0, 8); gap(2);

        cur_req = "R8";                                // R8 holdoff after stop, back-to-back
        os13_r = 0; div_r = 14'd0; ssel_r = 2'd2; gap(1);
        send(8'hC3, 0, 0, 2); send(8'h5A, 0, 0, 2); gap(3);
        ssel_r = 2'd1; gap(1);
        send(8'h81, 0, 0, 2); send(8'h7E, 0, 0, 3); gap(3);
        os13_r = 1; ssel_r = 2'd2; gap(1);
        send(8'h96, 0, 0, 2); send(8'h69, 0, 0, 4); gap(3);

        cur_req = "R9";                                // R9 1-stop stream, N=1
        os13_r = 0; ssel_r = 2'd0; gap(1);
        for (int k = 0; k < 4; k++) send(8'(8'h11 * k + 8'h0F), 0, 0, 2);
        gap(2);

        cur_req = "R10";                               // R10 larger divisor, edge timing
        div_r = 14'd3; db_r = 2'd3; gap(1);
        send(8'hF0, 0, 0, 2); gap(2);
        hold(1'b0, 8 * 4 + 3); gap(2);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog run did not complete, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule